// File: doc/BRIEF.md
# Register Stack Push/Pull Sequencer

This block moves a chosen set of CPU registers between the register file and a byte-wide memory stack, one byte per memory handshake. An 8-bit selection mask names the registers to move. A push walks the mask from its most significant bit down and stores each register below the current stack pointer. A pull walks the mask from bit 0 up, reads from the stack pointer upward, and writes each register back as soon as all of its bytes have arrived. The updated stack pointer is written back to the register file in the cycle that signals completion.

Two fixed sequences sit beside the mask-driven ones. The interrupt entry push stacks the whole machine state, sets the interrupt-mask bits and the "whole state saved" flag in the condition byte, and then fetches a new program counter from a fixed vector address. The interrupt return pulls the condition byte first. The saved flag in that byte decides whether the other registers follow or only the program counter does.

The surrounding core starts one operation at a time, reads the register file combinationally through the read port, and serves byte requests that stay stable until the ready input is seen high.

Top module: `stack_seq`

## Requirements
- R1: Register select codes on the register-file ports are CC=0, A=1, B=2, DP=3, X=4, Y=5, U=6, S=7, PC=8. Mask bit 7 selects PC, bit 6 the stack pointer that is not in use, bit 5 Y, bit 4 X, bit 3 DP, bit 2 B, bit 1 A and bit 0 CC. Bits 7..4 move 16 bits and bits 3..0 move 8 bits. Only the selected registers are transferred.
- R2: A push (op=0) moves the selected registers from mask bit 7 toward bit 0. A pull (op=1) moves them from bit 0 toward bit 7.
- R3: Each push byte goes to the stack pointer minus one, and the pointer then takes that value. Each pull byte comes from the stack pointer, and the pointer then increases by one. The final pointer is written back to the active stack register (S when use_user=0, U when use_user=1).
- R4: A 16-bit register sits in memory with its high byte at the lower address. A push writes the low byte first.
- R5: When use_user=1, mask bit 6 refers to S; when use_user=0 it refers to U.
- R6: Interrupt entry (op=2) pushes all eight mask positions in push order. It then sets CC to the old CC OR 0xD0 and loads PC from the big-endian word at 0xFFFA/0xFFFB.
- R7: Interrupt return (op=3) pulls CC first. If bit 7 of the pulled CC is 1, it then pulls A, B, DP, X, Y, the other stack pointer and PC in that order. Otherwise it pulls only PC.
- R8: done is high for exactly one cycle, in the cycle after the last byte handshake. A push or pull with a zero mask makes no memory request and raises done in the cycle after start, with the stack pointer unchanged.
- R9: A pulled register is written in the handshake cycle of its last byte, so a pulled PC is already in the register file while done is high.
- R10: A request holds mem_req, mem_we, mem_addr and mem_wdata unchanged until mem_rdy is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| op | input | 2 | 0 push, 1 pull, 2 interrupt entry, 3 interrupt return |
| mask | input | 8 | Register selection for push and pull |
| use_user | input | 1 | 1 selects U as the active stack, 0 selects S |
| done | output | 1 | One-cycle completion pulse |
| rf_rd_sel | output | 4 | Register-file read select |
| rf_rd_data | input | 16 | Combinational read data (byte registers in bits 7..0) |
| rf_wr_en | output | 1 | Register-file write strobe |
| rf_wr_sel | output | 4 | Register-file write select |
| rf_wr_data | output | 16 | Register-file write data |
| mem_req | output | 1 | Memory byte request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with mem_rdy |
| mem_rdy | input | 1 | Handshake completes when high with mem_req |

## Verification
The bench builds the block with its default parameters: a 16-bit address, 8-bit bytes, the vector at 0xFFFA and an OR pattern of 0xD0. With these values every mask position, both stack choices and both return lengths can be reached with a 256-byte memory model. Stacks near 0x80 and the vector folding onto 0xFA/0xFB keep all traffic inside that model. Ready is driven both always high and in a stalling pattern, which makes the done timing and the request-hold rule visible under waits.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;
  localparam int MASK_W = 8;
  localparam int IDX_W  = $clog2(MASK_W);
  localparam int SEL_W  = 4;

  typedef enum logic [1:0] {OP_PUSH = 2'd0, OP_PULL = 2'd1,
                            OP_IRQ = 2'd2, OP_RET = 2'd3} op_e;

  typedef enum logic [SEL_W-1:0] {
    RG_CC = 4'd0, RG_A = 4'd1, RG_B = 4'd2, RG_DP = 4'd3, RG_X = 4'd4,
    RG_Y = 4'd5, RG_U = 4'd6, RG_S = 4'd7, RG_PC = 4'd8
  } reg_e;

  typedef enum logic [2:0] {ST_IDLE, ST_SEL, ST_XFER, ST_CCSET,
                            ST_VEC, ST_FIN} state_e;

  // Mask positions with a 16-bit register
  function automatic logic is_wide(input logic [IDX_W-1:0] idx);
    return idx >= IDX_W'(4);
  endfunction

  // Remaining work after the condition byte of an interrupt return
  function automatic logic [MASK_W-1:0] ret_tail(input logic [7:0] cc);
    return cc[7] ? 8'hFE : 8'h80;
  endfunction

  function automatic reg_e active_sp(input logic user);
    return user ? RG_U : RG_S;
  endfunction
endpackage

// File: rtl/stack_seq_pick.sv
module stack_seq_pick
  import stack_seq_pkg::*;
#(
  parameter int MW = MASK_W,
  localparam int IW = $clog2(MW)
) (
  input  logic [MW-1:0] rem,
  input  logic          ascend,
  output logic [IW-1:0] idx,
  output logic          any
);
  assign any = |rem;

  always_comb begin
    idx = '0;
    if (ascend) begin
      for (int i = MW - 1; i >= 0; i--)
        if (rem[i]) idx = IW'(i);
    end else begin
      for (int i = 0; i < MW; i++)
        if (rem[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/stack_seq_regmap.sv
module stack_seq_regmap
  import stack_seq_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  input  logic             user,
  output reg_e             sel,
  output logic             wide
);
  assign wide = is_wide(idx);

  always_comb begin
    unique case (idx)
      3'd7:    sel = RG_PC;
      3'd6:    sel = user ? RG_S : RG_U;
      3'd5:    sel = RG_Y;
      3'd4:    sel = RG_X;
      3'd3:    sel = RG_DP;
      3'd2:    sel = RG_B;
      3'd1:    sel = RG_A;
      default: sel = RG_CC;
    endcase
  end
endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stack_seq_pkg::*;
#(
  parameter int          AW       = 16,
  parameter int          BW       = 8,
  parameter logic [15:0] VEC_ADDR = 16'hFFFA,
  parameter logic [7:0]  FLAG_SET = 8'hD0,
  localparam int         WW       = 2 * BW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [MASK_W-1:0] mask,
  input  logic              use_user,
  output logic              done,
  output logic [SEL_W-1:0]  rf_rd_sel,
  input  logic [WW-1:0]     rf_rd_data,
  output logic              rf_wr_en,
  output logic [SEL_W-1:0]  rf_wr_sel,
  output logic [WW-1:0]     rf_wr_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [BW-1:0]     mem_wdata,
  input  logic [BW-1:0]     mem_rdata,
  input  logic              mem_rdy
);
  state_e            st;
  op_e               op_q;
  logic              user_q;
  logic [AW-1:0]     sp;
  logic [MASK_W-1:0] rem;
  logic [WW-1:0]     hold;
  logic              second;

  // Named internal events for the checker
  logic              hs;
  logic              in_vec;
  logic              busy;
  logic              push_dir;
  logic              last_byte;
  logic [IDX_W-1:0]  idx;
  logic              any_left;
  reg_e              cur_sel;
  logic              cur_wide;
  logic [MASK_W-1:0] rem_next;
  logic [WW-1:0]     pulled;

  assign push_dir  = (op_q == OP_PUSH) || (op_q == OP_IRQ);
  assign busy      = (st != ST_IDLE);
  assign in_vec    = (st == ST_VEC);
  assign mem_req   = (st == ST_XFER) || in_vec;
  assign hs        = mem_req && mem_rdy;
  assign last_byte = !cur_wide || second;
  assign pulled    = {hold[BW-1:0], mem_rdata};
  assign done      = (st == ST_FIN);

  stack_seq_pick #(.MW(MASK_W)) u_pick (
    .rem(rem), .ascend(!push_dir), .idx(idx), .any(any_left));

  stack_seq_regmap u_map (
    .idx(idx), .user(user_q), .sel(cur_sel), .wide(cur_wide));

  always_comb begin
    if (op_q == OP_RET && idx == '0)
      rem_next = ret_tail(mem_rdata);
    else
      rem_next = rem & ~(MASK_W'(1) << idx);
  end

  always_comb begin
    mem_we    = (st == ST_XFER) && push_dir;
    mem_wdata = hold[BW-1:0];
    if (in_vec)        mem_addr = AW'(VEC_ADDR) + AW'(second);
    else if (push_dir) mem_addr = sp - AW'(1);
    else               mem_addr = sp;
  end

  always_comb begin
    unique case (st)
      ST_IDLE:  rf_rd_sel = active_sp(use_user);
      ST_CCSET: rf_rd_sel = RG_CC;
      default:  rf_rd_sel = cur_sel;
    endcase
  end

  always_comb begin
    rf_wr_en   = 1'b0;
    rf_wr_sel  = cur_sel;
    rf_wr_data = pulled;
    unique case (st)
      ST_XFER:  rf_wr_en = hs && last_byte && !push_dir;
      ST_CCSET: begin
        rf_wr_en   = 1'b1;
        rf_wr_sel  = RG_CC;
        rf_wr_data = WW'(rf_rd_data[BW-1:0] | FLAG_SET);
      end
      ST_VEC: begin
        rf_wr_en  = hs && second;
        rf_wr_sel = RG_PC;
      end
      ST_FIN: begin
        rf_wr_en   = 1'b1;
        rf_wr_sel  = active_sp(user_q);
        rf_wr_data = WW'(sp);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      op_q   <= OP_PUSH;
      user_q <= 1'b0;
      sp     <= '0;
      rem    <= '0;
      hold   <= '0;
      second <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (start) begin
          op_q   <= op_e'(op);
          user_q <= use_user;
          sp     <= rf_rd_data[AW-1:0];
          second <= 1'b0;
          unique case (op_e'(op))
            OP_IRQ:  begin rem <= '1;          st <= ST_SEL; end
            OP_RET:  begin rem <= MASK_W'(1);  st <= ST_SEL; end
            default: begin
              rem <= mask;
              st  <= (mask == '0) ? ST_FIN : ST_SEL;
            end
          endcase
        end
        ST_SEL: begin
          hold   <= push_dir ? rf_rd_data : '0;
          second <= 1'b0;
          st     <= any_left ? ST_XFER : ST_FIN;
        end
        ST_XFER: if (hs) begin
          sp   <= push_dir ? sp - AW'(1) : sp + AW'(1);
          hold <= push_dir ? (hold >> BW) : pulled;
          if (last_byte) begin
            rem <= rem_next;
            if (rem_next != '0)       st <= ST_SEL;
            else if (op_q == OP_IRQ)  st <= ST_CCSET;
            else                      st <= ST_FIN;
          end else begin
            second <= 1'b1;
          end
        end
        ST_CCSET: begin
          second <= 1'b0;
          hold   <= '0;
          st     <= ST_VEC;
        end
        ST_VEC: if (hs) begin
          hold <= pulled;
          if (second) st <= ST_FIN;
          else        second <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk #(
  parameter logic [15:0] VEC_ADDR = 16'hFFFA
) (
  input logic        clk,
  input logic        rst_n,
  input logic        done,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_rdy,
  input logic [15:0] mem_addr,
  input logic [7:0]  mem_wdata,
  input logic        hs,
  input logic        in_vec,
  input logic        busy
);
  a_r10_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) &&
                               $stable(mem_we) && $stable(mem_wdata)));

  a_r3_push_step: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && mem_we) |=> (!mem_req || !mem_we ||
                        mem_addr == $past(mem_addr) - 16'd1));

  a_r3_pull_step: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !mem_we && !in_vec) |=> (!mem_req || mem_we || in_vec ||
                                    mem_addr == $past(mem_addr) + 16'd1));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  a_r6_vec_read: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vec && mem_req) |-> (!mem_we && mem_addr[15:1] == VEC_ADDR[15:1]));
endmodule

bind stack_seq stack_seq_chk #(.VEC_ADDR(VEC_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .mem_req(mem_req),
  .mem_we(mem_we), .mem_rdy(mem_rdy), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .hs(hs), .in_vec(in_vec), .busy(busy));

// File: tb/stack_seq_bench.sv
`timescale 1ns/1ps
module stack_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        start = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [7:0]  mask = 8'd0;
  logic        use_user = 1'b0;
  logic        done;
  logic [3:0]  rf_rd_sel, rf_wr_sel;
  logic [15:0] rf_rd_data, rf_wr_data;
  logic        rf_wr_en;
  logic        mem_req, mem_we, mem_rdy;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  logic [15:0] rf [0:8];
  logic [15:0] ex [0:8];
  logic [7:0]  mem [0:255];

  int total = 0, bad = 0;
  int cyc = 0, last_hs = 0, start_cyc = 0;
  bit hs_in_op = 0;
  bit stall_mode = 0;
  int rdy_cnt = 0;
  bit wait_pend = 0;
  logic [15:0] wait_addr;

  typedef struct { logic [15:0] a; logic we; logic [7:0] d; } item_t;
  item_t q[$];

  assign rf_rd_data = (rf_rd_sel <= 4'd8) ? rf[rf_rd_sel] : 16'h0;
  assign mem_rdata  = mem[mem_addr[7:0]];

  stack_seq u_stack_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .mask(mask),
    .use_user(use_user), .done(done), .rf_rd_sel(rf_rd_sel),
    .rf_rd_data(rf_rd_data), .rf_wr_en(rf_wr_en), .rf_wr_sel(rf_wr_sel),
    .rf_wr_data(rf_wr_data), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_rdy(mem_rdy));

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory and register-file models
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req && mem_rdy && mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    if (rf_wr_en && rf_wr_sel <= 4'd8) rf[rf_wr_sel] <= rf_wr_data;
    #1;
    rdy_cnt++;
    mem_rdy = stall_mode ? (rdy_cnt % 3 != 0) : 1'b1;
  end

  // monitor: scoreboard pop, done timing, request hold
  always @(negedge clk) if (rst_n) begin
    if (start) begin start_cyc = cyc + 1; hs_in_op = 0; end
    if (wait_pend) begin
      check(mem_req && mem_addr == wait_addr, "R10", "held request",
            mem_addr, wait_addr);
      wait_pend = 0;
    end
    if (mem_req && !mem_rdy) begin wait_pend = 1; wait_addr = mem_addr; end
    if (mem_req && mem_rdy) begin
      item_t it;
      last_hs = cyc; hs_in_op = 1;
      if (q.size() == 0) begin
        check(0, "R1", "unexpected access", mem_addr, 16'h0);
      end else begin
        it = q.pop_front();
        check(mem_addr == it.a, "R2", "access address", mem_addr, it.a);
        check(mem_we == it.we, "R3", "access direction", 16'(mem_we), 16'(it.we));
        if (it.we)
          check(mem_wdata == it.d, "R4", "write byte", 16'(mem_wdata), 16'(it.d));
      end
    end
    if (done) begin
      if (hs_in_op)
        check(cyc == last_hs + 1, "R8", "done after last transfer",
              16'(cyc), 16'(last_hs + 1));
      else
        check(cyc == start_cyc, "R8", "done with zero mask",
              16'(cyc), 16'(start_cyc));
    end
  end

  function automatic int sel_of(input int b, input bit usr);
    case (b)
      7: return 8;
      6: return usr ? 7 : 6;
      default: return b;
    endcase
  endfunction

  task automatic ex_push(input int sel, input bit wide, inout int sp);
    if (wide) begin
      sp--; q.push_back('{16'(sp), 1'b1, rf[sel][7:0]});
      sp--; q.push_back('{16'(sp), 1'b1, rf[sel][15:8]});
    end else begin
      sp--; q.push_back('{16'(sp), 1'b1, rf[sel][7:0]});
    end
  endtask

  task automatic ex_pull(input int sel, input bit wide, inout int sp);
    logic [7:0] hi, lo;
    if (wide) begin
      hi = mem[sp[7:0]]; q.push_back('{16'(sp), 1'b0, hi}); sp++;
      lo = mem[sp[7:0]]; q.push_back('{16'(sp), 1'b0, lo}); sp++;
      ex[sel] = {hi, lo};
    end else begin
      lo = mem[sp[7:0]]; q.push_back('{16'(sp), 1'b0, lo}); sp++;
      ex[sel] = {8'h00, lo};
    end
  endtask

  task automatic run_op(input logic [1:0] o, input logic [7:0] m,
                        input bit usr, input string req);
    int sp, ai, n;
    bit pc_pulled;
    logic [7:0] cc;
    ai = usr ? 6 : 7;
    for (int i = 0; i < 9; i++) ex[i] = rf[i];
    sp = int'(rf[ai]);
    pc_pulled = 0;
    case (o)
      2'd0: for (int b = 7; b >= 0; b--) if (m[b]) ex_push(sel_of(b, usr), b >= 4, sp);
      2'd1: begin
        for (int b = 0; b < 8; b++) if (m[b]) ex_pull(sel_of(b, usr), b >= 4, sp);
        pc_pulled = m[7];
      end
      2'd2: begin
        for (int b = 7; b >= 0; b--) ex_push(sel_of(b, usr), b >= 4, sp);
        ex[0] = {8'h00, rf[0][7:0] | 8'hD0};
        q.push_back('{16'hFFFA, 1'b0, mem[8'hFA]});
        q.push_back('{16'hFFFB, 1'b0, mem[8'hFB]});
        ex[8] = {mem[8'hFA], mem[8'hFB]};
      end
      default: begin
        cc = mem[sp[7:0]];
        ex_pull(0, 0, sp);
        if (cc[7])
          for (int b = 1; b < 8; b++) ex_pull(sel_of(b, usr), b >= 4, sp);
        else
          ex_pull(8, 1, sp);
        pc_pulled = 1;
      end
    endcase
    ex[ai] = 16'(sp);
    @(posedge clk); #1;
    op = o; mask = m; use_user = usr; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    n = 0;
    @(negedge clk);
    while (!done && n < 400) begin @(negedge clk); n++; end
    check(done, req, "done seen", 16'(done), 16'h1);
    check(q.size() == 0, req, "all transfers made", 16'(q.size()), 16'h0);
    q.delete();
    if (pc_pulled)
      check(rf[8] == ex[8], "R9", "PC at done", rf[8], ex[8]);
    @(negedge clk);
    for (int i = 0; i < 9; i++)
      check(rf[i] == ex[i], req, $sformatf("register %0d after op", i), rf[i], ex[i]);
  endtask

  task automatic set_regs(input logic [15:0] s, input logic [15:0] u);
    rf[0] = 16'h0005; rf[1] = 16'h00A1; rf[2] = 16'h00B2; rf[3] = 16'h00D3;
    rf[4] = 16'h1234; rf[5] = 16'h5678; rf[6] = u; rf[7] = s; rf[8] = 16'hC0DE;
  endtask

  initial begin
    #150000;
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    mem[8'hFA] = 8'h9A; mem[8'hFB] = 8'hBC;
    set_regs(16'h0080, 16'h0040);
    mem_rdy = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!done, "R8", "reset done low", 16'(done), 16'h0);
    check(!mem_req, "R8", "reset no request", 16'(mem_req), 16'h0);

    // R1 R2 R4: full push on S
    run_op(2'd0, 8'hFF, 1'b0, "R1");
    // R2 R3: clobber, then full pull restores
    for (int i = 0; i < 7; i++) rf[i] = 16'h0000;
    rf[8] = 16'h0000;
    run_op(2'd1, 8'hFF, 1'b0, "R2");
    // R5: user stack, bit 6 moves S
    run_op(2'd0, 8'h40, 1'b1, "R5");
    run_op(2'd1, 8'h40, 1'b1, "R5");
    // R3 partial pull, stalling memory (R10)
    stall_mode = 1;
    run_op(2'd0, 8'h16, 1'b0, "R3");
    rf[1] = 16'h0; rf[2] = 16'h0; rf[4] = 16'h0;
    run_op(2'd1, 8'h16, 1'b0, "R3");
    // R8: zero mask, no access
    run_op(2'd0, 8'h00, 1'b0, "R8");
    run_op(2'd1, 8'h00, 1'b1, "R8");
    // R6: interrupt entry with entire flag preset, then R7 full return
    rf[0] = 16'h0085;
    run_op(2'd2, 8'h00, 1'b0, "R6");
    for (int i = 0; i < 6; i++) rf[i] = 16'h0000;
    rf[0] = 16'h0000;
    run_op(2'd3, 8'h00, 1'b0, "R7");
    // R7 short return: CC bit 7 clear
    stall_mode = 0;
    rf[0] = 16'h0005; rf[8] = 16'hBEEF;
    run_op(2'd0, 8'h81, 1'b0, "R7");
    rf[8] = 16'h0000; rf[1] = 16'h0077;
    run_op(2'd3, 8'h00, 1'b0, "R7");
    check(rf[1] == 16'h0077, "R7", "A untouched by short return", rf[1], 16'h0077);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule